// File: doc/BRIEF.md
# Slow-Domain Write Synchronizer

This bridge lets a fast bus clock write registers that live in a slow, always-on clock domain. The slow clock runs in the tens-of-kilohertz range. A write on the bus side is captured in a holding register and announced to the slow domain by flipping a request toggle. The slow domain waits a fixed number of its own cycles and then applies the write as a one-cycle strobe. It then flips an acknowledge toggle back to the bus domain. Each toggle crosses the boundary through a two-flop synchronizer.

The bus side shows four flags:

- **busy**: a write is in flight.
- **next**: a new write may be issued.
- **done**: the last synchronized write has landed.
- **err**: a write arrived while one was still in flight.

A write that arrives too early is dropped. A status-read pulse clears the done flag. The error flag is cleared by a synchronized write of the status address with the error bit set, and it clears when that write completes. The interrupt-enable register is written directly at bus speed and never goes through the slow path. The interrupt output is the OR of the enabled flags.

Top module: `lpw_bridge`

## Requirements
- R1: After reset the flags read busy=0, next=1, done=0, err=0, and irq=0 and lp_we=0.
- R2: A write on wr_valid to any address other than IE_ADDR, issued while busy=0, is accepted at that bus edge. From the next bus cycle busy=1 and next=0. lp_addr and lp_data hold the accepted address and data, unchanged, for as long as busy stays 1.
- R3: Each accepted write appears in the slow domain as exactly one slow cycle of lp_we, carrying the accepted address and data. The pulse is high in the slow cycle that begins SETTLE+2 or SETTLE+3 slow rising edges after the accepting bus edge.
- R4: Once the slow domain has applied the write, busy returns to 0 and done becomes 1 in the same bus cycle.
- R5: A bus cycle with rd_status=1 clears done in the next cycle. If a completion lands in the same cycle, the completion wins.
- R6: A synchronized write issued while busy=1 is rejected. err becomes 1 in the next bus cycle, no extra lp_we pulse occurs, and lp_data keeps the earlier write's value.
- R7: A synchronized write to ST_ADDR whose data bit 2 is 1 clears err when that write completes. The same write with bit 2 at 0 leaves err at 1.
- R8: A write to IE_ADDR updates the interrupt enables in the next bus cycle. Data bit 0 enables next, bit 1 enables done and bit 2 enables err. Such a write sets neither busy nor done and produces no lp_we pulse.
- R9: irq is 1 exactly when at least one flag is 1 whose enable bit is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Fast bus clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| clk_lp | input | 1 | Slow domain clock |
| rst_lp_n | input | 1 | Asynchronous active-low reset, slow domain |
| wr_valid | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_status | input | 1 | Status-read pulse; clears done |
| stat_busy | output | 1 | Synchronized write in flight |
| stat_next | output | 1 | A new synchronized write may be issued |
| stat_done | output | 1 | Last synchronized write completed |
| stat_err | output | 1 | Write arrived while busy |
| irq | output | 1 | OR of enabled flags |
| lp_we | output | 1 | Slow-domain write strobe |
| lp_addr | output | AW | Address applied with lp_we |
| lp_data | output | DW | Data applied with lp_we |

## Verification
The properties assume that wr_valid is a clean bus-domain pulse whose address and data are valid in that cycle. They also assume that the two clocks never share an edge, so the toggle handshake sees the request only after the holding registers have settled. The stimulus drives every input on the falling bus edge and uses slow and fast periods whose rising edges never coincide. Because the exact crossing delay is not known in advance, the bench polls for completion instead of waiting a fixed time. It also checks the slow-domain latency only within the one-cycle window that the two-flop synchronizer allows.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  // flag positions shared by status view, interrupt enables and clear data
  localparam int unsigned FLG_NEXT = 0;
  localparam int unsigned FLG_DONE = 1;
  localparam int unsigned FLG_ERR  = 2;
  localparam int unsigned FLG_W    = 3;
  typedef logic [FLG_W-1:0] flg_vec_t;
endpackage

// File: rtl/lpw_sync2.sv
module lpw_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= d;
      ff2_q <= ff1_q;
    end
  end

  assign q = ff2_q;
endmodule

// File: rtl/lpw_bus_side.sv
module lpw_bus_side #(
  parameter int unsigned AW      = 4,
  parameter int unsigned DW      = 16,
  parameter int unsigned IE_ADDR = 15,
  parameter int unsigned ST_ADDR = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_status,
  input  logic              ack_lvl,
  output logic              req_tgl,
  output logic [AW-1:0]     hold_addr,
  output logic [DW-1:0]     hold_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output lpw_pkg::flg_vec_t ie
);
  localparam logic [AW-1:0] IE_A = AW'(IE_ADDR);
  localparam logic [AW-1:0] ST_A = AW'(ST_ADDR);

  logic pend_q, pend_d, done_q, done_d, err_q, err_d;
  logic req_q, req_d, ackp_q;
  logic [AW-1:0] haddr_q, haddr_d;
  logic [DW-1:0] hdata_q, hdata_d;
  lpw_pkg::flg_vec_t ie_q, ie_d;
  logic ack_edge, is_ie, is_sync, hold_en;

  always_comb begin
    ack_edge = ack_lvl ^ ackp_q;
    is_ie    = wr_valid && (wr_addr == IE_A);
    is_sync  = wr_valid && (wr_addr != IE_A);
    hold_en  = is_sync && !pend_q;
    pend_d   = pend_q;
    done_d   = done_q;
    err_d    = err_q;
    req_d    = req_q;
    ie_d     = ie_q;
    haddr_d  = hold_en ? wr_addr : haddr_q;
    hdata_d  = hold_en ? wr_data : hdata_q;
    if (rd_status) done_d = 1'b0;
    if (ack_edge) begin
      pend_d = 1'b0;
      done_d = 1'b1;
      if (haddr_q == ST_A && hdata_q[lpw_pkg::FLG_ERR]) err_d = 1'b0;
    end
    if (is_ie) ie_d = wr_data[lpw_pkg::FLG_W-1:0];
    if (is_sync) begin
      if (pend_q) begin
        err_d = 1'b1;
      end else begin
        pend_d = 1'b1;
        req_d  = ~req_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      req_q   <= 1'b0;
      ackp_q  <= 1'b0;
      ie_q    <= '0;
      haddr_q <= '0;
      hdata_q <= '0;
    end else begin
      pend_q  <= pend_d;
      done_q  <= done_d;
      err_q   <= err_d;
      req_q   <= req_d;
      ackp_q  <= ack_lvl;
      ie_q    <= ie_d;
      haddr_q <= haddr_d;
      hdata_q <= hdata_d;
    end
  end

  assign req_tgl   = req_q;
  assign hold_addr = haddr_q;
  assign hold_data = hdata_q;
  assign busy      = pend_q;
  assign done      = done_q;
  assign err       = err_q;
  assign ie        = ie_q;
endmodule

// File: rtl/lpw_lp_side.sv
module lpw_lp_side #(
  parameter int unsigned SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_lvl,
  output logic lp_we,
  output logic ack_tgl
);
  localparam int unsigned CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE - 1);

  logic reqp_q, act_q, act_d, ack_q, ack_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic req_edge, fire;

  always_comb begin
    req_edge = req_lvl ^ reqp_q;
    fire     = act_q && (cnt_q == '0);
    act_d    = act_q;
    cnt_d    = cnt_q;
    if (req_edge) begin
      act_d = 1'b1;
      cnt_d = CNT_LOAD;
    end else if (fire) begin
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q - 1'b1;
    end
    ack_d = ack_q ^ fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqp_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      reqp_q <= req_lvl;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
    end
  end

  assign lp_we   = fire;
  assign ack_tgl = ack_q;
endmodule

// File: rtl/lpw_bridge.sv
module lpw_bridge #(
  parameter int unsigned AW      = 4,
  parameter int unsigned DW      = 16,
  parameter int unsigned SETTLE  = 4,
  parameter int unsigned IE_ADDR = 15,
  parameter int unsigned ST_ADDR = 14
) (
  input  logic          clk_bus,
  input  logic          rst_bus_n,
  input  logic          clk_lp,
  input  logic          rst_lp_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_status,
  output logic          stat_busy,
  output logic          stat_next,
  output logic          stat_done,
  output logic          stat_err,
  output logic          irq,
  output logic          lp_we,
  output logic [AW-1:0] lp_addr,
  output logic [DW-1:0] lp_data
);
  logic req_tgl, req_lp, ack_tgl, ack_bus;
  logic busy, done, err;
  lpw_pkg::flg_vec_t ie, flags;

  lpw_bus_side #(.AW(AW), .DW(DW), .IE_ADDR(IE_ADDR), .ST_ADDR(ST_ADDR)) u_bus (
    .clk(clk_bus), .rst_n(rst_bus_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_status(rd_status), .ack_lvl(ack_bus), .req_tgl(req_tgl),
    .hold_addr(lp_addr), .hold_data(lp_data), .busy(busy), .done(done), .err(err), .ie(ie)
  );

  lpw_sync2 u_req_sync (.clk(clk_lp), .rst_n(rst_lp_n), .d(req_tgl), .q(req_lp));
  lpw_sync2 u_ack_sync (.clk(clk_bus), .rst_n(rst_bus_n), .d(ack_tgl), .q(ack_bus));

  lpw_lp_side #(.SETTLE(SETTLE)) u_lp (
    .clk(clk_lp), .rst_n(rst_lp_n), .req_lvl(req_lp), .lp_we(lp_we), .ack_tgl(ack_tgl)
  );

  always_comb begin
    flags = '0;
    flags[lpw_pkg::FLG_NEXT] = ~busy;
    flags[lpw_pkg::FLG_DONE] = done;
    flags[lpw_pkg::FLG_ERR]  = err;
  end

  assign stat_busy = busy;
  assign stat_next = ~busy;
  assign stat_done = done;
  assign stat_err  = err;
  assign irq       = |(flags & ie);
endmodule

// File: rtl/lpw_bridge_chk.sv
module lpw_bridge_chk #(
  parameter int unsigned AW      = 4,
  parameter int unsigned DW      = 16,
  parameter int unsigned IE_ADDR = 15
) (
  input logic          clk_bus,
  input logic          rst_bus_n,
  input logic          clk_lp,
  input logic          rst_lp_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          rd_status,
  input logic          stat_busy,
  input logic          stat_done,
  input logic          stat_err,
  input logic          lp_we,
  input logic [AW-1:0] lp_addr,
  input logic [DW-1:0] lp_data
);
  localparam logic [AW-1:0] IE_A = AW'(IE_ADDR);

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_valid && wr_addr != IE_A && !stat_busy) |=> stat_busy); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (stat_busy && $past(stat_busy)) |-> ($stable(lp_addr) && $stable(lp_data))); // R2
  AST_WE_SINGLE: assert property (@(posedge clk_lp) disable iff (!rst_lp_n)
    lp_we |=> !lp_we); // R3
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (rd_status && !stat_busy) |=> !stat_done); // R5
  AST_OVERLAP_ERR: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_valid && wr_addr != IE_A && stat_busy) |=> stat_err); // R6
  AST_IE_NO_BUSY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_valid && wr_addr == IE_A && !stat_busy) |=> !stat_busy); // R8
endmodule

bind lpw_bridge lpw_bridge_chk #(.AW(AW), .DW(DW), .IE_ADDR(IE_ADDR)) u_chk (
  .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_lp(clk_lp), .rst_lp_n(rst_lp_n),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .rd_status(rd_status),
  .stat_busy(stat_busy), .stat_done(stat_done), .stat_err(stat_err),
  .lp_we(lp_we), .lp_addr(lp_addr), .lp_data(lp_data)
);

// File: tb/test_lpw_bridge.sv
module test_lpw_bridge;
  localparam int AW = 4, DW = 16, SETTLE = 4, IE_ADDR = 15, ST_ADDR = 14;

  logic clk_bus = 1'b0, clk_lp = 1'b0, rst_bus_n = 1'b0, rst_lp_n = 1'b0;
  logic wr_valid = 1'b0, rd_status = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic stat_busy, stat_next, stat_done, stat_err, irq, lp_we;
  logic [AW-1:0] lp_addr;
  logic [DW-1:0] lp_data;

  int checks = 0, errors = 0;
  int lp_edges = 0, we_cnt = 0, we_edge = 0, we_run = 0, t_start = 0, max_run = 0;
  logic [AW-1:0] we_addr = '0;
  logic [DW-1:0] we_data = '0;

  always #10 clk_bus = ~clk_bus;
  always #65 clk_lp = ~clk_lp;

  lpw_bridge #(.AW(AW), .DW(DW), .SETTLE(SETTLE), .IE_ADDR(IE_ADDR), .ST_ADDR(ST_ADDR)) i_lpw_bridge (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_lp(clk_lp), .rst_lp_n(rst_lp_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .rd_status(rd_status),
    .stat_busy(stat_busy), .stat_next(stat_next), .stat_done(stat_done), .stat_err(stat_err),
    .irq(irq), .lp_we(lp_we), .lp_addr(lp_addr), .lp_data(lp_data)
  );

  always @(posedge clk_lp) lp_edges <= lp_edges + 1;
  always @(negedge clk_lp) begin
    if (lp_we) begin
      we_cnt  <= we_cnt + 1;
      we_addr <= lp_addr;
      we_data <= lp_data;
      we_edge <= lp_edges;
      we_run  <= we_run + 1;
      if (we_run + 1 > max_run) max_run <= we_run + 1;
    end else begin
      we_run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_bus);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk_bus);
    #1 t_start = lp_edges;
    @(negedge clk_bus);
    wr_valid = 1'b0;
  endtask

  task automatic status_read();
    @(negedge clk_bus);
    rd_status = 1'b1;
    @(negedge clk_bus);
    rd_status = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_bus);
      if (!stat_busy) break;
    end
  endtask

  task automatic wait_bus(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_bus);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [DW-1:0] d0;
    wait_bus(4);
    rst_bus_n = 1'b1; rst_lp_n = 1'b1;
    @(negedge clk_bus);
    // R1 reset state
    chk(stat_busy == 0 && stat_next == 1, "R1 busy/next", {stat_busy, stat_next}, 1);
    chk(stat_done == 0 && stat_err == 0, "R1 done/err", {stat_done, stat_err}, 0);
    chk(irq == 0 && lp_we == 0, "R1 irq/lp_we", {irq, lp_we}, 0);

    // sweep over addresses: R2 R3 R4 R5
    for (int a = 0; a < 14; a++) begin
      d0 = DW'(a * 16'h1111) ^ 16'h00A5;
      base = we_cnt;
      bus_write(AW'(a), d0);
      chk(stat_busy == 1 && stat_next == 0, "R2 busy after accept", {stat_busy, stat_next}, 2);
      chk(lp_addr == AW'(a) && lp_data == d0, "R2 hold value", int'(lp_data), int'(d0));
      wait_idle();
      chk(we_cnt == base + 1, "R3 one strobe", we_cnt - base, 1);
      chk(we_addr == AW'(a) && we_data == d0, "R3 strobe payload", int'(we_data), int'(d0));
      chk(we_edge - t_start >= SETTLE + 2 && we_edge - t_start <= SETTLE + 3,
          "R3 latency", we_edge - t_start, SETTLE + 2);
      chk(stat_busy == 0 && stat_done == 1, "R4 completion", {stat_busy, stat_done}, 1);
      status_read();
      chk(stat_done == 0, "R5 read clears done", stat_done, 0);
    end
    chk(max_run == 1, "R3 strobe width", max_run, 1);

    // R6 overlapping write rejected
    base = we_cnt;
    bus_write(4'd3, 16'h1234);
    bus_write(4'd5, 16'hBEEF);
    chk(stat_err == 1, "R6 err on overlap", stat_err, 1);
    wait_idle();
    chk(we_cnt == base + 1, "R6 no extra strobe", we_cnt - base, 1);
    chk(we_data == 16'h1234 && lp_data == 16'h1234, "R6 data kept", int'(we_data), 16'h1234);

    // R7 clearing err
    bus_write(AW'(ST_ADDR), 16'h0003);
    wait_idle();
    chk(stat_err == 1, "R7 bit2 zero keeps err", stat_err, 1);
    bus_write(AW'(ST_ADDR), 16'h0004);
    chk(stat_err == 1, "R7 err held while busy", stat_err, 1);
    wait_idle();
    chk(stat_err == 0, "R7 err cleared on completion", stat_err, 0);

    // R8 / R9 interrupt enable path
    chk(stat_done == 1 && irq == 0, "R9 irq masked", irq, 0);
    status_read();
    base = we_cnt;
    bus_write(AW'(IE_ADDR), 16'h0002);
    chk(stat_busy == 0 && stat_done == 0, "R8 no busy/done", {stat_busy, stat_done}, 0);
    wait_bus(150);
    chk(we_cnt == base, "R8 no strobe", we_cnt - base, 0);
    chk(irq == 0, "R9 done enabled but clear", irq, 0);
    bus_write(4'd1, 16'h0055);
    wait_idle();
    chk(irq == 1, "R9 done irq", irq, 1);
    status_read();
    chk(irq == 0, "R9 done irq cleared", irq, 0);
    bus_write(AW'(IE_ADDR), 16'h0001);
    chk(irq == 1, "R8 R9 next irq immediate", irq, 1);
    bus_write(4'd2, 16'h0066);
    chk(irq == 0, "R9 next irq drops when busy", irq, 0);
    wait_idle();
    status_read();
    bus_write(AW'(IE_ADDR), 16'h0004);
    chk(irq == 0, "R9 err enabled but clear", irq, 0);
    bus_write(4'd4, 16'h0077);
    bus_write(4'd6, 16'h0088);
    chk(irq == 1, "R9 err irq", irq, 1);
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule